// File: doc/BRIEF.md
# Flag-Driven Stream Compactor

The block accepts a frame of up to `N_WORDS` data words on a valid/ready input stream. Each word carries a one-bit keep flag. It returns a dense output frame that holds only the kept words, in the order they arrived, and ends with one trailing beat that reports how many words were kept. Internally, the captured flags form a 0/1 vector. The block takes the exclusive prefix sum of that vector, so each kept word learns the output slot it must land in. A single scatter cycle then writes every kept word into its slot at once, and a drain stage plays the packed buffer out.

A frame closes when `in_last` is accepted or when its `N_WORDS`-th word is accepted, whichever comes first. Any slots that a short frame leaves unused count as not kept. From the accepted closing beat until the trailing count beat has been handed off, `in_ready` stays low. The block therefore holds exactly one frame at a time.

Back-pressure rules: an input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers on a rising edge where `out_valid` and `out_ready` are both high. Once the block raises `out_valid`, it keeps `out_valid` high and holds `out_data`, `out_last` and `out_count` unchanged until that beat transfers. The upstream side may hold `in_valid` for as long as it needs.

Top module: `stream_compactor`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The data beats of an output frame are exactly the input words whose `in_keep` was 1, in input order, with nothing between them. Words with `in_keep` = 0 never appear, whatever their data.
- R3: Every frame ends with one count beat: `out_last` = 1, `out_data` = 0, and `out_count` equal to the number of kept words. Data beats have `out_last` = 0.
- R4: A frame with no kept words produces only the count beat, with `out_count` = 0.
- R5: A full frame of `N_WORDS` kept words produces `N_WORDS` data beats and then a count of `N_WORDS`.
- R6: A frame closed early by `in_last` treats its unfilled positions as not kept, so no word from an earlier frame appears in its output.
- R7: When the `N_WORDS`-th word of a frame is accepted with `in_last` = 0, the frame closes anyway.
- R8: `in_ready` is 0 in the cycle after the closing input beat is accepted. It returns to 1 in the cycle after the count beat transfers.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data`, `out_last` and `out_count` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | DATA_W | Input word |
| in_keep | input | 1 | 1 = keep this word, 0 = drop it |
| in_last | input | 1 | Closes the frame with this word |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DATA_W | Kept word, or 0 on the count beat |
| out_last | output | 1 | Marks the count beat |
| out_count | output | $clog2(N_WORDS)+1 | Number of kept words in the frame |

## Verification
The bench targets the following cases, each with the failure it would expose:
- An all-dropped frame: an off-by-one drain pointer would emit a spurious data beat before the count.
- An all-kept frame: a count one bit too narrow would wrap to 0.
- A short frame sent right after a full one: stale keep flags would leak old words into the output.
- A frame of `N_WORDS` words with no `in_last`: a missing length limit would hang the input side.
- A stalled output sink: the block must hold its beat. A drain pointer that advances without a handshake would drop or repeat words.
- Each input handshake is checked against the timing rules for `in_ready`.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_SCAT  = 2'd1,
    ST_DRAIN = 2'd2
  } sc_state_t;
endpackage

// File: rtl/sc_prefix_scan.sv
module sc_prefix_scan #(
  parameter int N_WORDS = 8,
  parameter int CNT_W   = 4,
  parameter bit LOG_DEPTH = 1'b1
) (
  input  logic [N_WORDS-1:0]             flags,
  output logic [N_WORDS-1:0][CNT_W-1:0]  offs,
  output logic [CNT_W-1:0]               total
);
  localparam int STAGES = $clog2(N_WORDS);

  generate
    if (LOG_DEPTH) begin : g_log
      // doubling-stride inclusive sum, then subtract own flag
      logic [N_WORDS-1:0][CNT_W-1:0] lvl [STAGES+1];
      always_comb begin
        for (int i = 0; i < N_WORDS; i++) lvl[0][i] = CNT_W'(flags[i]);
        for (int s = 0; s < STAGES; s++) begin
          for (int i = 0; i < N_WORDS; i++) begin
            int src;
            src = (i >= (1 << s)) ? i - (1 << s) : 0;
            lvl[s+1][i] = lvl[s][i] + ((i >= (1 << s)) ? lvl[s][src] : '0);
          end
        end
        for (int i = 0; i < N_WORDS; i++) offs[i] = lvl[STAGES][i] - CNT_W'(flags[i]);
        total = lvl[STAGES][N_WORDS-1];
      end
    end else begin : g_ripple
      always_comb begin
        offs[0] = '0;
        for (int i = 1; i < N_WORDS; i++) offs[i] = offs[i-1] + CNT_W'(flags[i-1]);
        total = offs[N_WORDS-1] + CNT_W'(flags[N_WORDS-1]);
      end
    end
  endgenerate
endmodule

// File: rtl/sc_scatter.sv
module sc_scatter #(
  parameter int N_WORDS = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [N_WORDS-1:0][DATA_W-1:0]    src_data,
  input  logic [N_WORDS-1:0]                src_keep,
  input  logic [N_WORDS-1:0][CNT_W-1:0]     src_offs,
  input  logic [CNT_W-1:0]                  src_total,
  output logic [N_WORDS-1:0][DATA_W-1:0]    packed_q,
  output logic [CNT_W-1:0]                  count_q
);
  logic [N_WORDS-1:0][DATA_W-1:0] packed_d;

  // each slot gathers the one kept source whose offset names it
  always_comb begin
    for (int j = 0; j < N_WORDS; j++) begin
      packed_d[j] = '0;
      for (int i = 0; i < N_WORDS; i++) begin
        if (src_keep[i] && (src_offs[i] == CNT_W'(j))) packed_d[j] = packed_d[j] | src_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      packed_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      packed_q <= packed_d;
      count_q  <= src_total;
    end
  end

  // scan total must agree with the raw flag population (R3)
  p_total_matches_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (32'(src_total) == $countones(src_keep)));
endmodule

// File: rtl/sc_drain.sv
module sc_drain #(
  parameter int N_WORDS = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [N_WORDS-1:0][DATA_W-1:0]  packed_buf,
  input  logic [CNT_W-1:0]                kept,
  output logic                            done,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [DATA_W-1:0]               out_data,
  output logic                            out_last,
  output logic [CNT_W-1:0]                out_count
);
  localparam int IDX_W = $clog2(N_WORDS);

  logic             busy;
  logic [CNT_W-1:0] rd_ptr;
  logic             at_count;
  logic             fire;

  assign at_count  = (rd_ptr == kept);
  assign out_valid = busy;
  assign out_last  = busy && at_count;
  assign out_data  = (busy && !at_count) ? packed_buf[rd_ptr[IDX_W-1:0]] : '0;
  assign out_count = kept;
  assign fire      = busy && out_ready;
  assign done      = fire && at_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rd_ptr <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      rd_ptr <= '0;
    end else if (fire) begin
      if (at_count) busy <= 1'b0;
      else          rd_ptr <= rd_ptr + 1'b1;
    end
  end

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_count));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (32'(out_count) <= N_WORDS));

  p_count_beat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_data == '0));
endmodule

// File: rtl/stream_compactor.sv
module stream_compactor #(
  parameter int N_WORDS   = 8,
  parameter int DATA_W    = 16,
  parameter bit LOG_DEPTH = 1'b1,
  localparam int CNT_W    = $clog2(N_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_keep,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  out_count
);
  import sc_pkg::*;
  localparam int IDX_W = $clog2(N_WORDS);

  sc_state_t                       state;
  logic [N_WORDS-1:0][DATA_W-1:0]  word_q;
  logic [N_WORDS-1:0]              keep_q;
  logic [IDX_W-1:0]                wr_idx;
  logic [N_WORDS-1:0][CNT_W-1:0]   offs;
  logic [CNT_W-1:0]                total;
  logic [N_WORDS-1:0][DATA_W-1:0]  packed_q;
  logic [CNT_W-1:0]                count_q;
  logic                            drain_done;
  logic                            in_fire;
  logic                            closing;

  assign in_ready = (state == ST_FILL);
  assign in_fire  = in_valid && in_ready;
  assign closing  = in_last || (wr_idx == IDX_W'(N_WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      word_q <= '0;
      keep_q <= '0;
      wr_idx <= '0;
    end else begin
      case (state)
        ST_FILL: if (in_fire) begin
          word_q[wr_idx] <= in_data;
          keep_q[wr_idx] <= in_keep;
          if (closing) begin
            state  <= ST_SCAT;
            wr_idx <= '0;
          end else begin
            wr_idx <= wr_idx + 1'b1;
          end
        end
        ST_SCAT: state <= ST_DRAIN;
        ST_DRAIN: if (drain_done) begin
          state  <= ST_FILL;
          keep_q <= '0;   // unfilled slots of the next frame read as dropped
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  sc_prefix_scan #(.N_WORDS(N_WORDS), .CNT_W(CNT_W), .LOG_DEPTH(LOG_DEPTH)) u_scan (
    .flags (keep_q),
    .offs  (offs),
    .total (total)
  );

  sc_scatter #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_scatter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state == ST_SCAT),
    .src_data  (word_q),
    .src_keep  (keep_q),
    .src_offs  (offs),
    .src_total (total),
    .packed_q  (packed_q),
    .count_q   (count_q)
  );

  sc_drain #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (state == ST_SCAT),
    .packed_buf (packed_q),
    .kept       (count_q),
    .done       (drain_done),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_count  (out_count)
  );

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);

  p_ready_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/sim_stream_compactor.sv
module sim_stream_compactor;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int CW = $clog2(N) + 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_keep = 0, in_last = 0, out_ready = 1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_count;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] wd [N];
  bit            kp [N];

  always #5 clk = ~clk;

  stream_compactor #(.N_WORDS(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_count(out_count));

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drives one frame, collects and checks its output
  task automatic run_frame(string req, int len, bit with_last, bit bp);
    logic [DW-1:0] expv [N];
    logic [DW-1:0] got [N+1];
    int ek = 0, gn = 0, cyc = 0;
    bit done = 0, stalled = 0;
    logic [DW-1:0] snap_d;
    logic snap_l;
    logic [CW-1:0] snap_c;
    for (int i = 0; i < len; i++) if (kp[i]) begin expv[ek] = wd[i]; ek++; end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = wd[i]; in_keep = kp[i];
      in_last = with_last && (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_keep = 0;
    check(in_ready == 0, "R8", {req, " ready low after close"}, int'(in_ready), 0);
    while (!done && cyc < 200) begin
      cyc++;
      out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (stalled) begin
        check(out_valid && out_data == snap_d && out_last == snap_l && out_count == snap_c,
              "R9", {req, " held beat"}, int'(out_data), int'(snap_d));
        stalled = 0;
      end
      if (out_valid && !out_ready) begin
        stalled = 1; snap_d = out_data; snap_l = out_last; snap_c = out_count;
      end else if (out_valid && out_ready) begin
        if (out_last) begin
          done = 1;
          check(int'(out_count) == ek, "R3", {req, " count"}, int'(out_count), ek);
          check(out_data == '0, "R3", {req, " count beat data"}, int'(out_data), 0);
        end else if (gn < N + 1) begin
          got[gn] = out_data; gn++;
        end
      end
      @(negedge clk);
    end
    out_ready = 1;
    check(done, "R3", {req, " count beat seen"}, int'(done), 1);
    check(gn == ek, "R2", {req, " data beat total"}, gn, ek);
    for (int k = 0; k < ek && k < gn; k++)
      check(got[k] == expv[k], "R2", {req, " packed word"}, int'(got[k]), int'(expv[k]));
    check(in_ready == 1, "R8", {req, " ready back"}, int'(in_ready), 1);
  endtask

  task automatic t_reset;
    check(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_mixed;   // R2 R3: keep pattern 1,0,1,1,0,0,1,0
    bit pat [N] = '{1,0,1,1,0,0,1,0};
    for (int i = 0; i < N; i++) begin wd[i] = 16'hA000 + 16'(i); kp[i] = pat[i]; end
    run_frame("R2 mixed", N, 1, 0);
  endtask

  task automatic t_none;    // R4
    for (int i = 0; i < N; i++) begin wd[i] = 16'hBEEF; kp[i] = 0; end
    run_frame("R4 none kept", N, 1, 0);
  endtask

  task automatic t_all_bp;  // R5 R9
    for (int i = 0; i < N; i++) begin wd[i] = 16'h1100 + 16'(i * 3); kp[i] = 1; end
    run_frame("R5 all kept", N, 1, 1);
  endtask

  task automatic t_short;   // R6: follows a full kept frame
    bit pat [N] = '{1,0,1,1,0,0,0,0};
    for (int i = 0; i < N; i++) begin wd[i] = 16'h5500 + 16'(i); kp[i] = pat[i]; end
    run_frame("R6 short", 5, 1, 0);
  endtask

  task automatic t_nolast;  // R7
    for (int i = 0; i < N; i++) begin wd[i] = 16'h7700 + 16'(i); kp[i] = (i % 2 == 1); end
    run_frame("R7 no last", N, 0, 1);
  endtask

  task automatic t_single;  // R2 R6
    wd[0] = 16'hC0DE; kp[0] = 1;
    run_frame("R2 single", 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_none();
    t_all_bp();
    t_short();
    t_nolast();
    t_single();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule